// File: doc/BRIEF.md
# Byte Lane Manipulation Unit

This unit is one execution slice of a 64-bit integer pipeline. It handles byte-granular masking, insertion, extraction and zeroing. A single issue carries a 7-bit function code, two 64-bit operands, an 8-bit literal with a select flag, and three register numbers. Each operation reduces to the same three steps: an optional byte shift before, a byte-keep selector turned into a 64-bit AND mask, and an optional byte shift after. Insert-low masks first and shifts afterwards. Extract masks last. The mask family shifts a size pattern across the selector rather than shifting the data.

The result is formed combinationally and registered once. A two-state controller sequences the output. In `ST_IDLE`, no result is presented. In `ST_SHOW`, the registered result, write enable and error flag are valid. The controller has three transitions:

- **issue**: `ST_IDLE` to `ST_SHOW`, taken when `in_valid` is high.
- **drain**: `ST_SHOW` to `ST_IDLE`, taken when `in_valid` is low.
- **stream**: `ST_SHOW` to `ST_SHOW`, taken on back-to-back issues.

Top module: `byte_lane_unit`

## Requirements
- R1: Zapnot (code 0x31) keeps byte i of A where selector bit i is 1 and clears it where the bit is 0. Selector 0xFF returns A unchanged and selector 0x00 returns zero.
- R2: Zap (code 0x30) clears byte i of A where selector bit i is 1. Selector 0x00 returns A and selector 0xFF returns zero.
- R3: The selector and the byte shift count come from the literal when `lit_sel`=1, otherwise from B. The shift count is bits [2:0] of that value. B reads zero when `rb_num`=31.
- R4: Function bits [5:4] pick the size: 0 gives byte mask 0x01, 1 gives word 0x03, 2 gives longword 0x0F and 3 gives quadword 0xFF.
- R5: Insert-low (codes 0x0B, 0x1B, 0x2B, 0x3B) keeps the size-masked low bytes of A. It then shifts them left by 8×count bits, and bits beyond bit 63 are lost.
- R6: Mask-low (codes 0x02, 0x12, 0x22, 0x32) clears the A bytes selected by bits [7:0] of (size mask << count). Bits of that product above bit 7 have no effect.
- R7: Mask-high (codes 0x52, 0x62, 0x72) clears the A bytes selected by bits [15:8] of (size mask << count). Only bytes that spilled past byte 7 are cleared.
- R8: Extract-low (codes 0x06, 0x16, 0x26, 0x36) shifts A right by 8×count bits and then keeps the size-masked low bytes.
- R9: Extract-high (codes 0x5A, 0x6A, 0x7A) shifts A left by 8×((8−count) mod 8) bits and then keeps the size-masked low bytes. A count of 0 therefore does not shift.
- R10: When `ra_num`=31, operand A reads as zero, so the result is zero for every valid code.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high.
- R12: `wr_en` is high with `out_valid` only when the code is known and `rc_num` is not 31. The result is still presented when `rc_num` is 31.
- R13: Any code outside those listed above gives result zero, with `out_err` high and `wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| func | input | 7 | Function code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| lit | input | 8 | Literal operand |
| lit_sel | input | 1 | Use literal instead of B |
| ra_num | input | 5 | Source register number of A |
| rb_num | input | 5 | Source register number of B |
| rc_num | input | 5 | Destination register number |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |
| wr_en | output | 1 | Register write enable |
| out_err | output | 1 | Unknown function code |

## Verification
A stuck controller state shows at the ports within one cycle. Either `out_valid` stays high through an idle gap, or it misses the cycle after an issue. A wrong decode or a mis-built selector shows on the very next result as a wrong byte lane, or as a missing or spurious `out_err`. A faulty shifter corrupts only the byte lanes its count moves, so the bench sweeps every count against every size in random traffic. Register-31 handling is visible on the same cycle through `result` and `wr_en`.

// File: rtl/blu_pkg.sv
package blu_pkg;

    localparam int unsigned FUNC_W = 7;

    typedef enum logic [2:0] {
        FAM_ZAPNOT,
        FAM_ZAP,
        FAM_MSKL,
        FAM_MSKH,
        FAM_INSL,
        FAM_EXTL,
        FAM_EXTH,
        FAM_BAD
    } fam_e;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } st_e;

    localparam logic [FUNC_W-1:0] CODE_ZAP    = 7'h30;
    localparam logic [FUNC_W-1:0] CODE_ZAPNOT = 7'h31;

endpackage

// File: rtl/blu_decode.sv
module blu_decode
    import blu_pkg::*;
#(
    parameter int unsigned NBYTES = 8
) (
    input  logic [FUNC_W-1:0] func,
    output fam_e              fam,
    output logic [NBYTES-1:0] size_keep,
    output logic              bad
);

    logic [3:0] low_nib;
    logic       high_bit;
    logic [1:0] size_idx;

    assign low_nib  = func[3:0];
    assign high_bit = func[6];
    assign size_idx = func[5:4];

    always_comb begin
        fam = FAM_BAD;
        if (func == CODE_ZAP) begin
            fam = FAM_ZAP;
        end else if (func == CODE_ZAPNOT) begin
            fam = FAM_ZAPNOT;
        end else begin
            unique case (low_nib)
                4'h2: begin
                    if (!high_bit)           fam = FAM_MSKL;
                    else if (size_idx != 0)  fam = FAM_MSKH;
                end
                4'hB: if (!high_bit)                   fam = FAM_INSL;
                4'h6: if (!high_bit)                   fam = FAM_EXTL;
                4'hA: if (high_bit && size_idx != 0)   fam = FAM_EXTH;
                default: fam = FAM_BAD;
            endcase
        end
    end

    assign bad = (fam == FAM_BAD);

    // Size pattern: the low 2**size_idx bytes are kept.
    for (genvar g = 0; g < NBYTES; g++) begin : g_size
        assign size_keep[g] = (g < (1 << size_idx));
    end

    // R4: a known code always yields a contiguous low-byte size pattern
    always_comb begin
        if (!bad) begin
            a_r4_size_pattern: assert (((size_keep + 1'b1) & size_keep) == '0);
        end
    end

endmodule

// File: rtl/blu_keep_mask.sv
module blu_keep_mask #(
    parameter int unsigned NBYTES = 8,
    localparam int unsigned DW    = 8 * NBYTES
) (
    input  logic [NBYTES-1:0] keep,
    output logic [DW-1:0]     and_mask
);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign and_mask[8*g +: 8] = {8{keep[g]}};
    end

endmodule

// File: rtl/blu_byte_shift.sv
module blu_byte_shift #(
    parameter int unsigned NBYTES  = 8,
    parameter bit          TO_LEFT = 1'b1,
    localparam int unsigned DW     = 8 * NBYTES,
    localparam int unsigned SHW    = $clog2(NBYTES)
) (
    input  logic [DW-1:0]  din,
    input  logic [SHW-1:0] nbytes,
    output logic [DW-1:0]  dout
);

    logic [SHW+2:0] nbits;
    assign nbits = {nbytes, 3'b000};

    if (TO_LEFT) begin : g_left
        assign dout = din << nbits;
    end else begin : g_right
        assign dout = din >> nbits;
    end

endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
    import blu_pkg::*;
#(
    parameter int unsigned NBYTES   = 8,
    parameter int unsigned REG_W    = 5,
    parameter int unsigned ZERO_REG = 31,
    localparam int unsigned DW      = 8 * NBYTES,
    localparam int unsigned SHW     = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [6:0]        func,
    input  logic [63:0]       opa,
    input  logic [63:0]       opb,
    input  logic [7:0]        lit,
    input  logic              lit_sel,
    input  logic [4:0]        ra_num,
    input  logic [4:0]        rb_num,
    input  logic [4:0]        rc_num,
    output logic              out_valid,
    output logic [63:0]       result,
    output logic              wr_en,
    output logic              out_err
);

    // ---------------- operand fetch ----------------
    logic [DW-1:0]     a_eff;
    logic [DW-1:0]     b_eff;
    logic [SHW-1:0]    cnt;
    logic [SHW-1:0]    cnt_neg;
    logic [NBYTES-1:0] sel_byte;

    assign a_eff    = (ra_num == REG_W'(ZERO_REG)) ? '0 : opa;
    assign b_eff    = lit_sel ? DW'(lit)
                    : ((rb_num == REG_W'(ZERO_REG)) ? '0 : opb);
    assign cnt      = b_eff[SHW-1:0];
    assign cnt_neg  = '0 - cnt;
    assign sel_byte = b_eff[NBYTES-1:0];

    // ---------------- decode ----------------
    fam_e              fam;
    logic [NBYTES-1:0] size_keep;
    logic              bad;

    blu_decode #(.NBYTES(NBYTES)) i_decode (
        .func      (func),
        .fam       (fam),
        .size_keep (size_keep),
        .bad       (bad)
    );

    // size pattern slid across a double-width selector
    logic [2*NBYTES-1:0] slid;
    assign slid = {{NBYTES{1'b0}}, size_keep} << cnt;

    // ---------------- pre shift ----------------
    logic [DW-1:0] pre_right;
    logic [DW-1:0] pre_left;

    blu_byte_shift #(.NBYTES(NBYTES), .TO_LEFT(1'b0)) i_pre_right (
        .din    (a_eff),
        .nbytes (cnt),
        .dout   (pre_right)
    );

    blu_byte_shift #(.NBYTES(NBYTES), .TO_LEFT(1'b1)) i_pre_left (
        .din    (a_eff),
        .nbytes (cnt_neg),
        .dout   (pre_left)
    );

    // ---------------- zap primitive ----------------
    logic [DW-1:0]     zap_in;
    logic [NBYTES-1:0] keep;
    logic [DW-1:0]     and_mask;
    logic [DW-1:0]     zapped;

    always_comb begin
        zap_in = a_eff;
        keep   = '0;
        unique case (fam)
            FAM_ZAPNOT: keep = sel_byte;
            FAM_ZAP:    keep = ~sel_byte;
            FAM_MSKL:   keep = ~slid[NBYTES-1:0];
            FAM_MSKH:   keep = ~slid[2*NBYTES-1:NBYTES];
            FAM_INSL:   keep = size_keep;
            FAM_EXTL: begin
                zap_in = pre_right;
                keep   = size_keep;
            end
            FAM_EXTH: begin
                zap_in = pre_left;
                keep   = size_keep;
            end
            default:    keep = '0;
        endcase
    end

    blu_keep_mask #(.NBYTES(NBYTES)) i_keep_mask (
        .keep     (keep),
        .and_mask (and_mask)
    );

    assign zapped = zap_in & and_mask;

    // ---------------- post shift (insert) ----------------
    logic [DW-1:0] ins_out;
    logic [DW-1:0] res_next;

    blu_byte_shift #(.NBYTES(NBYTES), .TO_LEFT(1'b1)) i_post_left (
        .din    (zapped),
        .nbytes (cnt),
        .dout   (ins_out)
    );

    assign res_next = bad ? '0 : ((fam == FAM_INSL) ? ins_out : zapped);

    // ---------------- controller ----------------
    st_e state_q;
    st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_SHOW;   // issue
            ST_SHOW: if (!in_valid) state_d = ST_IDLE;   // drain, else stream
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    logic [DW-1:0] res_q;
    logic          wr_q;
    logic          err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            wr_q  <= 1'b0;
            err_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= res_next;
            wr_q  <= !bad && (rc_num != REG_W'(ZERO_REG));
            err_q <= bad;
        end
    end

    assign out_valid = (state_q == ST_SHOW);
    assign result    = res_q;
    assign wr_en     = out_valid && wr_q;
    assign out_err   = out_valid && err_q;

    // ---------------- assertions ----------------
    a_r11_issue_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r13_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (result == '0) && !wr_en);

    a_r12_dest_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rc_num == REG_W'(ZERO_REG)) |=> !wr_en);

    a_r10_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ra_num == REG_W'(ZERO_REG)) |=> (result == '0));

    a_r1_zapnot_all: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func == CODE_ZAPNOT && lit_sel && lit == 8'hFF)
        |=> (result == $past(a_eff)));

    a_r2_zap_all: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func == CODE_ZAP && lit_sel && lit == 8'hFF)
        |=> (result == '0));

endmodule

// File: tb/test_byte_lane_unit.sv
module test_byte_lane_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [6:0]  func = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [7:0]  lit = '0;
    logic        lit_sel = 1'b0;
    logic [4:0]  ra_num = '0;
    logic [4:0]  rb_num = '0;
    logic [4:0]  rc_num = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        wr_en;
    logic        out_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    byte_lane_unit i_byte_lane_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func),
        .opa(opa), .opb(opb), .lit(lit), .lit_sel(lit_sel),
        .ra_num(ra_num), .rb_num(rb_num), .rc_num(rc_num),
        .out_valid(out_valid), .result(result), .wr_en(wr_en), .out_err(out_err)
    );

    logic [6:0] codes [20] = '{7'h30, 7'h31, 7'h02, 7'h12, 7'h22, 7'h32,
                               7'h0B, 7'h1B, 7'h2B, 7'h3B, 7'h06, 7'h16,
                               7'h26, 7'h36, 7'h52, 7'h62, 7'h72, 7'h5A,
                               7'h6A, 7'h7A};

    function automatic bit known(input logic [6:0] f);
        for (int i = 0; i < 20; i++) if (codes[i] == f) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [63:0] lanes(input logic [7:0] k);
        logic [63:0] m = '0;
        for (int i = 0; i < 8; i++) if (k[i]) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [63:0] model(input logic [6:0] f, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [2:0]  sh   = b[2:0];
        logic [7:0]  szm  = 8'((16'd1 << (16'd1 << f[5:4])) - 16'd1);
        logic [15:0] slid = {8'h00, szm} << sh;
        if (!known(f)) return '0;
        if (f == 7'h31) return a & lanes(b[7:0]);
        if (f == 7'h30) return a & ~lanes(b[7:0]);
        case (f[3:0])
            4'h2: return f[6] ? (a & ~lanes(slid[15:8])) : (a & ~lanes(slid[7:0]));
            4'hB: return (a & lanes(szm)) << (8 * sh);
            4'h6: return (a >> (8 * sh)) & lanes(szm);
            default: return (a << ((64 - 8 * int'(sh)) % 64)) & lanes(szm);
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns one negedge later with outputs checked.
    task automatic send(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                        input logic [7:0] l, input bit ls, input logic [4:0] ra,
                        input logic [4:0] rb, input logic [4:0] rc, input string tag);
        logic [63:0] ae, be, exp;
        bit expw, expe;
        func = f; opa = a; opb = b; lit = l; lit_sel = ls;
        ra_num = ra; rb_num = rb; rc_num = rc; in_valid = 1'b1;
        ae   = (ra == 5'd31) ? 64'd0 : a;
        be   = ls ? {56'd0, l} : ((rb == 5'd31) ? 64'd0 : b);
        exp  = model(f, ae, be);
        expe = !known(f);
        expw = known(f) && (rc != 5'd31);
        @(negedge clk);
        chk(out_valid == 1'b1, {tag, " R11 valid"}, 64'(out_valid), 64'd1);
        chk(result == exp, {tag, " result"}, result, exp);
        chk(wr_en == expw, {tag, " R12 wr_en"}, 64'(wr_en), 64'(expw));
        chk(out_err == expe, {tag, " R13 err"}, 64'(out_err), 64'(expe));
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 idle valid", 64'(out_valid), 64'd0);
        chk(wr_en == 1'b0, "R12 idle wr_en", 64'(wr_en), 64'd0);
    endtask

    localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "reset R11 valid", 64'(out_valid), 64'd0);
        chk(result == 64'd0, "reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        send(7'h31, PAT, 0, 8'hFF, 1, 1, 2, 3, "R1 zapnot ff");
        send(7'h31, PAT, 0, 8'h00, 1, 1, 2, 3, "R1 zapnot 00");
        send(7'h31, PAT, 0, 8'hA5, 1, 1, 2, 3, "R1 zapnot a5");
        send(7'h30, PAT, 0, 8'h00, 1, 1, 2, 3, "R2 zap 00");
        send(7'h30, PAT, 0, 8'hFF, 1, 1, 2, 3, "R2 zap ff");
        send(7'h30, PAT, 64'h3C, 8'h00, 0, 1, 2, 3, "R2 zap from B R3");
        send(7'h30, PAT, 64'h3C, 8'h00, 0, 1, 31, 3, "R3 B reg31");
        send(7'h0B, PAT, 64'hFFF8, 8'h00, 0, 1, 2, 3, "R3 R5 count low bits");
        send(7'h3B, PAT, 0, 8'd3, 1, 1, 2, 3, "R5 insql drop");
        send(7'h2B, PAT, 0, 8'd6, 1, 1, 2, 3, "R4 R5 insll edge");
        send(7'h1B, PAT, 0, 8'd7, 1, 1, 2, 3, "R4 R5 inswl edge");
        send(7'h22, PAT, 0, 8'd6, 1, 1, 2, 3, "R6 mskll spill");
        send(7'h12, PAT, 0, 8'd3, 1, 1, 2, 3, "R6 mskwl");
        send(7'h72, PAT, 0, 8'd0, 1, 1, 2, 3, "R7 mskqh zero");
        send(7'h62, PAT, 0, 8'd6, 1, 1, 2, 3, "R7 msklh spill");
        send(7'h06, PAT, 0, 8'd7, 1, 1, 2, 3, "R8 extbl");
        send(7'h36, PAT, 0, 8'd2, 1, 1, 2, 3, "R4 R8 extql");
        send(7'h7A, PAT, 0, 8'd0, 1, 1, 2, 3, "R9 extqh zero");
        send(7'h6A, PAT, 0, 8'd5, 1, 1, 2, 3, "R9 extlh");
        send(7'h3B, PAT, 0, 8'd0, 1, 31, 2, 3, "R10 ra31");
        send(7'h31, PAT, 0, 8'hFF, 1, 1, 2, 31, "R12 rc31");
        send(7'h7F, PAT, 0, 8'hFF, 1, 1, 2, 3, "R13 bad 7f");
        send(7'h42, PAT, 0, 8'd1, 1, 1, 2, 3, "R13 bad mskbh");
        idle();
        idle();

        for (int n = 0; n < 600; n++) begin
            logic [6:0] f;
            if ($urandom_range(15) == 0) f = 7'($urandom);
            else f = codes[$urandom_range(19)];
            send(f, {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom),
                 1'($urandom), 5'($urandom_range(31)), 5'($urandom_range(31)),
                 5'($urandom_range(31)), "R1-R13 random");
            if ($urandom_range(7) == 0) idle();
        end
        idle();

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule